// File: doc/BRIEF.md
# Dual-Stream Frame Transmit Engine

This block turns a sequence of transmit descriptors into two outgoing streams. One is a 32-bit sideband control stream that carries per-frame metadata. The other is a byte-wide packet data stream. A descriptor arrives on a valid/ready handshake. It carries a start flag, an end flag, a byte count and a 20-byte metadata field. The descriptor's payload bytes then follow on a separate byte input with its own handshake.

When a descriptor opens a frame, the block sends its metadata field on the control stream as five 32-bit words, and it clears the frame's fill position. Payload bytes from the opening descriptor and any later descriptors are collected in an internal frame buffer. Nothing leaves on the data stream until a descriptor that closes the frame has had all of its bytes taken. The whole frame is then replayed in order, and a one-cycle completion pulse follows the final byte. The buffer has a fixed capacity. Any extra bytes are consumed and discarded, and the frame is marked as truncated.

Top module: `dsx_tx_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `ctl_valid`, `dat_valid`, `done` and `in_ready` are low and `desc_ready` is high.
- R2: Each accepted descriptor with `desc_sof` high produces exactly CTL_WORDS (5) control beats. `ctl_last` is high on the fifth beat only.
- R3: Control word k (k = 0 first) carries metadata bytes 4k..4k+3 in little-endian order. Byte i of `desc_app` is bits [8i+7:8i], and byte 4k lands in bits [7:0] of the word.
- R4: A descriptor with `desc_sof` low emits no control beats. Its bytes are appended after the bytes already collected for the current frame.
- R5: Each descriptor takes exactly `desc_len` bytes from the byte input. A descriptor with length 0 takes none, and the block returns to accepting descriptors.
- R6: The data stream stays silent until every byte of a descriptor with `desc_eof` high has been taken. It then emits all collected bytes in arrival order, with `dat_last` high on the final byte only.
- R7: `ctl_valid` and `dat_valid` are never high in the same cycle, so the control words of a frame are all accepted before its first data byte is offered.
- R8: On both output streams, while valid is high and ready is low, valid stays high and the beat's data and flags stay unchanged. No beat is lost or repeated.
- R9: `done` is a one-cycle pulse in the cycle after the final data beat is accepted. A frame that closes with no bytes collected pulses `done` without any data beat.
- R10: At most MAX_FRAME bytes are kept per frame. When bytes beyond that are discarded, `dat_err` is high on the final data beat and `done_err` is high with `done`. In every other case both stay low.
- R11: A descriptor with `desc_sof` high discards any bytes collected since the previous frame closed.
- R12: `desc_ready` and `in_ready` are never both high. `desc_ready` is low while a closed frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_sof | input | 1 | Descriptor opens a frame |
| desc_eof | input | 1 | Descriptor closes a frame |
| desc_len | input | LEN_W (15) | Payload bytes belonging to this descriptor |
| desc_app | input | CTL_WORDS*32 (160) | Per-frame metadata field, byte i at bits [8i+7:8i] |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte can be taken |
| in_data | input | 8 | Payload byte |
| ctl_valid | output | 1 | Control beat valid |
| ctl_ready | input | 1 | Control sink ready |
| ctl_data | output | 32 | Control word |
| ctl_last | output | 1 | Final control word of the frame |
| dat_valid | output | 1 | Data beat valid |
| dat_ready | input | 1 | Data sink ready |
| dat_data | output | 8 | Data byte |
| dat_last | output | 1 | Final byte of the frame |
| dat_err | output | 1 | Frame was truncated, on the final byte |
| done | output | 1 | Frame completion pulse |
| done_err | output | 1 | Completed frame was truncated |

## Verification
The bench builds frames from several descriptors, including zero-length ones and a restart that opens a new frame before the previous one has closed. A block that failed to clear its fill position would replay stale bytes, and one that mishandled a zero byte count would stall. The control and data streams are throttled in several patterns, so a design that moved a beat on a stalled cycle would drop or duplicate a word. The bench checks frames of exactly the buffer capacity and just above it. An off-by-one in the capacity limit would either flag a full frame as truncated or write past the buffer, and the bench also confirms that the truncation flag is cleared for the next frame. The byte order inside each metadata word is compared against a byte-level model, which exposes a swapped word order or swapped byte order.

// File: rtl/dsx_pkg.sv
package dsx_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CTRL,
    ST_LOAD,
    ST_SEND
  } dsx_state_e;
endpackage

// File: rtl/dsx_ctl_serializer.sv
// Shifts a multi-word metadata field out as a burst of words, lowest word first.
module dsx_ctl_serializer #(
  parameter int WORDS  = 5,
  parameter int WORD_W = 32,
  localparam int FIELD_W = WORDS * WORD_W,
  localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FIELD_W-1:0] field,
  output logic               valid,
  input  logic               ready,
  output logic [WORD_W-1:0]  data,
  output logic               last,
  output logic               finish
);
  logic [FIELD_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic               at_end;

  assign at_end = (idx == IDX_W'(WORDS - 1));
  assign data   = shreg[WORD_W-1:0];
  assign last   = valid && at_end;
  assign finish = valid && ready && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      idx   <= '0;
      valid <= 1'b0;
    end else if (start) begin
      shreg <= field;
      idx   <= '0;
      valid <= 1'b1;
    end else if (valid && ready) begin
      shreg <= shreg >> WORD_W;
      idx   <= idx + 1'b1;
      if (at_end) valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dsx_frame_ram.sv
// Simple dual-port frame store with a registered read port.
module dsx_frame_ram #(
  parameter int DEPTH = 2048,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dsx_tx_engine.sv
module dsx_tx_engine
  import dsx_pkg::*;
#(
  parameter int CTL_WORDS = 5,
  parameter int MAX_FRAME = 2048,
  parameter int LEN_W     = 15,
  localparam int APP_W    = CTL_WORDS * WORD_W,
  localparam int POS_W    = $clog2(MAX_FRAME + 1),
  localparam int AW       = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic              desc_sof,
  input  logic              desc_eof,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [APP_W-1:0]  desc_app,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              ctl_valid,
  input  logic              ctl_ready,
  output logic [WORD_W-1:0] ctl_data,
  output logic              ctl_last,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [BYTE_W-1:0] dat_data,
  output logic              dat_last,
  output logic              dat_err,
  output logic              done,
  output logic              done_err
);
  dsx_state_e       state;
  logic [LEN_W-1:0] remain;
  logic             eof_q;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] rd_ptr;
  logic             trunc;

  logic desc_fire, byte_fire, ctl_start, ctl_finish, room, issue, final_rd;

  assign desc_ready = (state == ST_IDLE);
  assign in_ready   = (state == ST_LOAD) && (remain != '0);
  assign desc_fire  = desc_valid && desc_ready;
  assign byte_fire  = in_valid && in_ready;
  assign ctl_start  = desc_fire && desc_sof;
  assign room       = (pos < POS_W'(MAX_FRAME));
  assign issue      = (state == ST_SEND) && (rd_ptr < pos) && (!dat_valid || dat_ready);
  assign final_rd   = (rd_ptr == pos - 1'b1);

  dsx_ctl_serializer #(.WORDS(CTL_WORDS), .WORD_W(WORD_W)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .start  (ctl_start),
    .field  (desc_app),
    .valid  (ctl_valid),
    .ready  (ctl_ready),
    .data   (ctl_data),
    .last   (ctl_last),
    .finish (ctl_finish)
  );

  dsx_frame_ram #(.DEPTH(MAX_FRAME), .W(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (byte_fire && room),
    .waddr (pos[AW-1:0]),
    .wdata (in_data),
    .re    (issue),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (dat_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      remain    <= '0;
      eof_q     <= 1'b0;
      pos       <= '0;
      rd_ptr    <= '0;
      trunc     <= 1'b0;
      dat_valid <= 1'b0;
      dat_last  <= 1'b0;
      dat_err   <= 1'b0;
      done      <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;

      // Output register fed by the synchronous read port.
      if (issue) begin
        dat_valid <= 1'b1;
        dat_last  <= final_rd;
        dat_err   <= trunc && final_rd;
        rd_ptr    <= rd_ptr + 1'b1;
      end else if (dat_ready) begin
        dat_valid <= 1'b0;
      end

      unique case (state)
        ST_IDLE: begin
          if (desc_fire) begin
            remain <= desc_len;
            eof_q  <= desc_eof;
            if (desc_sof) begin
              pos   <= '0;
              trunc <= 1'b0;
              state <= ST_CTRL;
            end else begin
              state <= ST_LOAD;
            end
          end
        end
        ST_CTRL: begin
          if (ctl_finish) state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (byte_fire) begin
            remain <= remain - 1'b1;
            if (room) pos   <= pos + 1'b1;
            else      trunc <= 1'b1;
          end else if (remain == '0) begin
            if (!eof_q) begin
              state <= ST_IDLE;
            end else if (pos == '0) begin
              done     <= 1'b1;
              done_err <= trunc;
              trunc    <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              rd_ptr <= '0;
              state  <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (dat_valid && dat_ready && dat_last) begin
            done     <= 1'b1;
            done_err <= trunc;
            trunc    <= 1'b0;
            pos      <= '0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsx_tx_checker.sv
module dsx_tx_checker #(
  parameter int CTL_WORDS = 5,
  parameter int MAX_FRAME = 2048,
  localparam int CC_W = $clog2(CTL_WORDS + 1),
  localparam int DC_W = $clog2(MAX_FRAME + 1) + 1
) (
  input logic        clk,
  input logic        rst,
  input logic        desc_ready,
  input logic        in_ready,
  input logic        ctl_valid,
  input logic        ctl_ready,
  input logic [31:0] ctl_data,
  input logic        ctl_last,
  input logic        dat_valid,
  input logic        dat_ready,
  input logic [7:0]  dat_data,
  input logic        dat_last,
  input logic        dat_err,
  input logic        done
);
  logic [CC_W-1:0] ctl_cnt;
  logic [DC_W-1:0] dat_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_cnt <= '0;
      dat_cnt <= '0;
    end else begin
      if (ctl_valid && ctl_ready) ctl_cnt <= ctl_last ? '0 : ctl_cnt + 1'b1;
      if (dat_valid && dat_ready) dat_cnt <= dat_last ? '0 : dat_cnt + 1'b1;
    end
  end

  assert_ctl_count_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_valid && ctl_ready) |-> (ctl_last == (ctl_cnt == CC_W'(CTL_WORDS - 1))));

  assert_ctl_order_R7: assert property (@(posedge clk) disable iff (rst)
    dat_valid |-> !ctl_valid);

  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_data) && $stable(ctl_last)));

  assert_dat_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && !dat_ready) |=>
      (dat_valid && $stable(dat_data) && $stable(dat_last) && $stable(dat_err)));

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && dat_ready && dat_last) |=> done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_frame_cap_R10: assert property (@(posedge clk) disable iff (rst)
    dat_valid |-> (dat_cnt < DC_W'(MAX_FRAME)));

  assert_ready_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(desc_ready && in_ready));
endmodule

bind dsx_tx_engine dsx_tx_checker #(.CTL_WORDS(CTL_WORDS), .MAX_FRAME(MAX_FRAME)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .desc_ready (desc_ready),
  .in_ready   (in_ready),
  .ctl_valid  (ctl_valid),
  .ctl_ready  (ctl_ready),
  .ctl_data   (ctl_data),
  .ctl_last   (ctl_last),
  .dat_valid  (dat_valid),
  .dat_ready  (dat_ready),
  .dat_data   (dat_data),
  .dat_last   (dat_last),
  .dat_err    (dat_err),
  .done       (done)
);

// File: tb/sim_dsx_tx_engine.sv
module sim_dsx_tx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NW   = 5;
  localparam int MAXF = 32;
  localparam int LW   = 15;
  localparam int APPW = NW * 32;

  logic clk, rst;
  logic desc_valid, desc_ready, desc_sof, desc_eof;
  logic [LW-1:0] desc_len;
  logic [APPW-1:0] desc_app;
  logic in_valid, in_ready;
  logic [7:0] in_data;
  logic ctl_valid, ctl_ready, ctl_last;
  logic [31:0] ctl_data;
  logic dat_valid, dat_ready, dat_last, dat_err;
  logic [7:0] dat_data;
  logic done, done_err;

  dsx_tx_engine #(.CTL_WORDS(NW), .MAX_FRAME(MAXF), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_sof(desc_sof),
    .desc_eof(desc_eof), .desc_len(desc_len), .desc_app(desc_app),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data), .ctl_last(ctl_last),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .dat_last(dat_last), .dat_err(dat_err),
    .done(done), .done_err(done_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int mode = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [32:0] exp_ctl [$];   // {last, word}
  logic [9:0]  exp_dat [$];   // {err, last, byte}
  logic        exp_done [$];
  logic [7:0]  fq [$];
  logic        fq_err = 1'b0;

  logic last_hs = 1'b0;
  logic ctl_stall = 1'b0, dat_stall = 1'b0;
  logic [32:0] ctl_prev;
  logic [9:0]  dat_prev;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] app_byte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7) + 8'(i >> 2);
  endfunction

  // Monitor and sink-ready generator: ready is set first, then handshakes are judged.
  always @(negedge clk) begin
    logic [32:0] ec;
    logic [9:0]  ed;
    logic        eb;
    cycles++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      1:       begin ctl_ready = ~ctl_ready; dat_ready = ~dat_ready; end
      2:       begin ctl_ready = lfsr[1] | lfsr[4]; dat_ready = lfsr[2] | lfsr[7]; end
      default: begin ctl_ready = 1'b1; dat_ready = 1'b1; end
    endcase
    if (!rst) begin
      if (last_hs) chk(done === 1'b1, "R9", "done after last beat", {63'd0, done}, 64'd1);
      last_hs = 1'b0;
      if (done) begin
        if (exp_done.size() == 0) chk(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
        else begin
          eb = exp_done.pop_front();
          chk(done_err === eb, "R10", "done_err", {63'd0, done_err}, {63'd0, eb});
        end
      end
      if (ctl_stall)
        chk(ctl_valid && {ctl_last, ctl_data} == ctl_prev, "R8", "ctl held under stall",
            {30'd0, ctl_valid, ctl_last, ctl_data}, {30'd0, 1'b1, ctl_prev});
      if (dat_stall)
        chk(dat_valid && {dat_err, dat_last, dat_data} == dat_prev, "R8", "dat held under stall",
            {53'd0, dat_valid, dat_err, dat_last, dat_data}, {53'd0, 1'b1, dat_prev});
      if (dat_valid && ctl_valid) chk(1'b0, "R7", "ctl and dat both valid", 64'd1, 64'd0);
      if (desc_ready && in_ready) chk(1'b0, "R12", "both readies high", 64'd1, 64'd0);
      if (desc_ready && dat_valid) chk(1'b0, "R12", "desc_ready while sending", 64'd1, 64'd0);
      if (ctl_valid && ctl_ready) begin
        if (exp_ctl.size() == 0) chk(1'b0, "R2", "extra control beat", {31'd0, ctl_last, ctl_data}, 64'd0);
        else begin
          ec = exp_ctl.pop_front();
          chk({ctl_last, ctl_data} === ec, "R2 R3", "control beat",
              {31'd0, ctl_last, ctl_data}, {31'd0, ec});
        end
      end
      if (dat_valid && dat_ready) begin
        if (exp_dat.size() == 0) chk(1'b0, "R6", "extra data beat", {54'd0, dat_err, dat_last, dat_data}, 64'd0);
        else begin
          ed = exp_dat.pop_front();
          chk({dat_err, dat_last, dat_data} === ed, "R4 R6 R10 R11", "data beat",
              {54'd0, dat_err, dat_last, dat_data}, {54'd0, ed});
        end
        if (dat_last) last_hs = 1'b1;
      end
      ctl_stall = ctl_valid && !ctl_ready;
      ctl_prev  = {ctl_last, ctl_data};
      dat_stall = dat_valid && !dat_ready;
      dat_prev  = {dat_err, dat_last, dat_data};
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Driver: offers one descriptor, feeds its bytes, and records expectations.
  task automatic put_desc(input bit sof, input bit eof, input int len,
                          input logic [7:0] aseed, input logic [7:0] dseed);
    logic [APPW-1:0] app;
    int gap;
    for (int i = 0; i < NW * 4; i++) app[8*i +: 8] = app_byte(aseed, i);
    if (sof) begin
      fq.delete();
      fq_err = 1'b0;
      for (int k = 0; k < NW; k++)
        exp_ctl.push_back({k == NW - 1, app_byte(aseed, 4*k+3), app_byte(aseed, 4*k+2),
                           app_byte(aseed, 4*k+1), app_byte(aseed, 4*k)});
    end
    @(negedge clk);
    desc_sof = sof; desc_eof = eof; desc_len = LW'(len); desc_app = app;
    desc_valid = 1'b1;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      in_data  = dseed + 8'(i);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (fq.size() < MAXF) fq.push_back(dseed + 8'(i));
      else fq_err = 1'b1;
      in_valid = 1'b0;
      if (mode == 2 && lfsr[3]) @(negedge clk);
    end
    if (len == 0 && !eof) begin
      gap = 0;
      // R5: a zero-length descriptor takes no bytes and frees the descriptor port.
      while (!desc_ready && gap < 20) begin
        chk(!in_ready, "R5", "in_ready on zero-length", {63'd0, in_ready}, 64'd0);
        @(negedge clk);
        gap++;
      end
      chk(desc_ready, "R5", "desc_ready after zero-length", {63'd0, desc_ready}, 64'd1);
    end
    if (eof) begin
      for (int j = 0; j < fq.size(); j++)
        exp_dat.push_back({(j == fq.size() - 1) && fq_err, j == fq.size() - 1, fq[j]});
      exp_done.push_back(fq_err);
      fq.delete();
      fq_err = 1'b0;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_ctl.size() != 0 || exp_dat.size() != 0 || exp_done.size() != 0 ||
            !desc_ready) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    desc_valid = 1'b0; desc_sof = 1'b0; desc_eof = 1'b0; desc_len = '0; desc_app = '0;
    in_valid = 1'b0; in_data = '0;
    ctl_ready = 1'b1; dat_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 and R12: idle outputs under reset.
    chk(!ctl_valid, "R1", "ctl_valid in reset", {63'd0, ctl_valid}, 64'd0);
    chk(!dat_valid, "R1", "dat_valid in reset", {63'd0, dat_valid}, 64'd0);
    chk(!done, "R1", "done in reset", {63'd0, done}, 64'd0);
    chk(desc_ready, "R1", "desc_ready in reset", {63'd0, desc_ready}, 64'd1);
    chk(!in_ready, "R12", "in_ready in reset", {63'd0, in_ready}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ctl_valid && !dat_valid && desc_ready, "R1", "idle after reset",
        {61'd0, ctl_valid, dat_valid, desc_ready}, 64'd1);

    // Single-descriptor frame (R2 R3 R6 R9).
    put_desc(1'b1, 1'b1, 5, 8'h10, 8'hA0);
    drain();

    // Multi-descriptor frame with a zero-length piece, alternating backpressure (R4 R5).
    mode = 1;
    put_desc(1'b1, 1'b0, 3, 8'h31, 8'h20);
    put_desc(1'b0, 1'b0, 0, 8'h00, 8'h00);
    put_desc(1'b0, 1'b0, 4, 8'h00, 8'h40);
    put_desc(1'b0, 1'b1, 2, 8'h00, 8'h60);
    drain();

    // Frame that closes with no bytes (R9).
    put_desc(1'b1, 1'b1, 0, 8'h55, 8'h00);
    drain();

    // Restart before close discards earlier bytes (R11).
    mode = 2;
    put_desc(1'b1, 1'b0, 4, 8'h71, 8'h80);
    put_desc(1'b1, 1'b1, 3, 8'h92, 8'hC0);
    drain();

    // Capacity boundary, then overflow, then a clean frame (R10).
    put_desc(1'b1, 1'b1, MAXF, 8'h05, 8'h01);
    drain();
    put_desc(1'b1, 1'b0, 20, 8'h06, 8'h30);
    put_desc(1'b0, 1'b1, 20, 8'h00, 8'h70);
    drain();
    mode = 0;
    put_desc(1'b1, 1'b1, 6, 8'hE7, 8'hF0);
    drain();

    chk(exp_ctl.size() == 0, "R2", "control beats outstanding", 64'(exp_ctl.size()), 64'd0);
    chk(exp_dat.size() == 0, "R6", "data beats outstanding", 64'(exp_dat.size()), 64'd0);
    chk(exp_done.size() == 0, "R9", "done pulses outstanding", 64'(exp_done.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule